// File: doc/BRIEF.md
# Rate-Scalable Folded FIR Filter

This block is a single-channel FIR filter for 16-bit signed samples that produces 32-bit results. It has sixteen multiply-accumulate slots. A two-bit speed field lets the filter reuse those slots over 1, 2, 4 or 8 clock phases for each sample. A lower sample rate therefore buys a longer filter: 16, 32, 64 or 128 taps. In the half-rate setting, a decimate control keeps the two-clock input rate, produces a result only for every second sample, and spans 64 taps.

The coefficients sit in a 128-word memory written through an address/data/strobe port. The tap address selects how many samples back a coefficient applies. The filter runs while the enable input is high. A rate strobe output marks the sample period so that upstream logic can pace its data. Speed, decimate and coefficient writes are meant to change only while enable is low. The delay line is never cleared by a mode change, so the first windows of a run include the samples held from the run before it.

Top module: `rate_fold_fir`

## Requirements
- R1: After reset, `res_vld` is 0, `res` is 0, `rate_clk` is 1, and every delay-line word is 0.
- R2: `speed` = 0, 1, 2, 3 takes one sample every 1, 2, 4, 8 clocks and forms the result over the 16, 32, 64, 128 most recent samples. While `speed` is not 0, two results are never on consecutive cycles.
- R3: Each result equals the low 32 bits of the exact sum over taps t of coef[t] × x[n−t], where x[n] is the newest sample and coef[t] is the word written at address t. Both operands are signed and no intermediate sum overflows.
- R4: The first sample is taken at the first rising edge at which `en` is high. After that, a sample is taken every sample period for as long as `en` stays high. Input values between sampling edges are ignored.
- R5: A result whose newest sample was taken at edge E is shown with `res_vld` high for exactly one cycle, following edge E+P+3. P is the period in clocks: 1, 2, 4 or 8, or 4 when decimating.
- R6: `rate_clk` stays 1 when `speed` = 0 and while `en` is low. Otherwise, it is 1 during the last half of each sample period, meaning the cycles nearest the sampling edge, and 0 during the first half.
- R7: With `speed` = 1 and `decim` = 1, samples are taken every 2 clocks. One result is made for each pair of samples, over the 64 most recent samples, with the second sample of the pair as the newest. The first result shows after edge 10 counted from enable.
- R8: `decim` has no effect when `speed` is 0, 2 or 3.
- R9: While `en` is low, no sample is taken, the delay line holds its contents, `res_vld` is 0, and results still in flight are discarded. On re-enable, sampling restarts as in R4.
- R10: A high `cw_we` at a rising edge stores `cw_data` as the coefficient for tap `cw_addr`. Bits [3:0] of the address select the slot and bits [6:4] select the phase. The stored value is used by all later results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Filter run enable |
| speed | input | 2 | Fold factor select: 0 full rate, 1 half, 2 quarter, 3 eighth |
| decim | input | 1 | Decimate-by-two select, used with speed 1 only |
| din | input | 16 | Signed input sample |
| cw_we | input | 1 | Coefficient write strobe |
| cw_addr | input | 7 | Coefficient tap address |
| cw_data | input | 16 | Signed coefficient word |
| res | output | 32 | Filter result, low 32 bits |
| res_vld | output | 1 | One-cycle result strobe |
| rate_clk | output | 1 | Sample-period marker |

## Verification
The filter is driven with a slow ramp, an alternating-sign stream, a pseudo-random stream, an impulse followed by a sparse pattern, and full-scale alternating data. The ramp and the alternating stream expose a reversed tap order or a wrong phase-to-slot mapping. The impulse shows the first sample landing in tap 0 at the exact latency. Full-scale data against full-scale coefficients forces the 32-bit truncation. A run with an enable gap checks that held samples stay in the window while the input is discarded. Repeating a run after a coefficient rewrite, and running the decimating mode against the eighth-rate mode with the decimate bit set, separates the pair-shift path from the single-shift path.

// File: rtl/fir_fold_pkg.sv
package fir_fold_pkg;

  typedef enum logic [1:0] {
    SPD_FULL    = 2'd0,
    SPD_HALF    = 2'd1,
    SPD_QUARTER = 2'd2,
    SPD_EIGHTH  = 2'd3
  } speed_e;

  // last phase index of one sample period for a speed setting
  function automatic int fold_last_phase(logic [1:0] spd, logic dec_on);
    if (dec_on) return 3;
    return (1 << spd) - 1;
  endfunction

endpackage

// File: rtl/fir_fold_ctrl.sv
module fir_fold_ctrl
  import fir_fold_pkg::*;
#(
  parameter int PHW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [1:0]     speed,
  input  logic           decim,
  output logic [PHW-1:0] ph,
  output logic           ph_first,
  output logic           ph_last,
  output logic           shift_one,
  output logic           shift_two,
  output logic           pend_ld,
  output logic           run,
  output logic           rate_clk
);

  logic           dec_on;
  logic [PHW-1:0] last_ph;
  logic [PHW-1:0] half_ph;
  logic [PHW-1:0] idle_ph;
  logic [PHW-1:0] ph_nxt;
  logic           take_edge;

  always_comb begin
    dec_on  = decim && (speed == SPD_HALF);
    last_ph = PHW'(fold_last_phase(speed, dec_on));
    half_ph = (last_ph >> 1) + PHW'(1);
    idle_ph = dec_on ? PHW'(1) : last_ph;
    if (!en)                ph_nxt = idle_ph;
    else if (ph == last_ph) ph_nxt = '0;
    else                    ph_nxt = ph + PHW'(1);
  end

  assign ph_first  = (ph == '0);
  assign ph_last   = (ph == last_ph);
  assign take_edge = en && ph_last;
  assign shift_one = take_edge && !dec_on;
  assign shift_two = take_edge && dec_on;
  assign pend_ld   = en && dec_on && (ph == PHW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= idle_ph;
      run      <= 1'b0;
      rate_clk <= 1'b1;
    end else begin
      ph  <= ph_nxt;
      run <= en && (run || take_edge);
      if (speed == SPD_FULL) rate_clk <= 1'b1;
      else if (dec_on)       rate_clk <= ph_nxt[0];
      else                   rate_clk <= (ph_nxt >= half_ph);
    end
  end

  // R6: full-rate setting keeps the marker high
  p_rate_full_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(speed) == 2'd0) |-> rate_clk);

endmodule

// File: rtl/fir_fold_coef.sv
module fir_fold_coef #(
  parameter int CW    = 16,
  parameter int SLOTS = 16,
  parameter int PHW   = 3
) (
  input  logic                        clk,
  input  logic                        wr_en,
  input  logic [$clog2(SLOTS)+PHW-1:0] wr_addr,
  input  logic [CW-1:0]               wr_data,
  input  logic [PHW-1:0]              rd_ph,
  output logic [SLOTS-1:0][CW-1:0]    coef_q
);

  localparam int SLW   = $clog2(SLOTS);
  localparam int DEPTH = 1 << PHW;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [CW-1:0] mem [DEPTH];
    logic [CW-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_en && (wr_addr[SLW-1:0] == SLW'(s)))
        mem[wr_addr[SLW+PHW-1:SLW]] <= wr_data;
      rd_q <= mem[rd_ph];
    end

    assign coef_q[s] = rd_q;
  end

endmodule

// File: rtl/fir_fold_line.sv
module fir_fold_line #(
  parameter int DW    = 16,
  parameter int SLOTS = 16,
  parameter int PHW   = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     shift_one,
  input  logic                     shift_two,
  input  logic                     pend_ld,
  input  logic [DW-1:0]            din,
  input  logic [PHW-1:0]           rd_ph,
  output logic [SLOTS-1:0][DW-1:0] slice_q,
  output logic [DW-1:0]            newest
);

  localparam int SLW  = $clog2(SLOTS);
  localparam int TAPS = SLOTS << PHW;

  logic [DW-1:0] tap [TAPS];
  logic [DW-1:0] pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) tap[i] <= '0;
      pend <= '0;
    end else begin
      if (pend_ld) pend <= din;
      if (shift_one) begin
        tap[0] <= din;
        for (int i = 1; i < TAPS; i++) tap[i] <= tap[i-1];
      end else if (shift_two) begin
        tap[0] <= din;
        tap[1] <= pend;
        for (int i = 2; i < TAPS; i++) tap[i] <= tap[i-2];
      end
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_rd
    logic [DW-1:0] rd_q;
    always_ff @(posedge clk) rd_q <= tap[{rd_ph, SLW'(s)}];
    assign slice_q[s] = rd_q;
  end

  assign newest = tap[0];

endmodule

// File: rtl/fir_fold_mac.sv
module fir_fold_mac #(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int SLOTS = 16,
  parameter int OW    = 32,
  parameter int AW    = 39
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     in_v,
  input  logic                     in_first,
  input  logic                     in_last,
  input  logic [SLOTS-1:0][CW-1:0] coef,
  input  logic [SLOTS-1:0][DW-1:0] data,
  output logic [OW-1:0]            res,
  output logic                     res_vld
);

  localparam int PW = DW + CW;

  logic [SLOTS-1:0][PW-1:0] prod_q;
  logic                     p_v, p_first, p_last;
  logic [AW-1:0]            sum;
  logic [AW-1:0]            acc;
  logic                     a_last;

  for (genvar s = 0; s < SLOTS; s++) begin : g_mul
    logic signed [PW-1:0] prod_r;
    always_ff @(posedge clk) prod_r <= $signed(data[s]) * $signed(coef[s]);
    assign prod_q[s] = prod_r;
  end

  always_comb begin
    sum = '0;
    for (int s = 0; s < SLOTS; s++)
      sum = sum + {{(AW-PW){prod_q[s][PW-1]}}, prod_q[s]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_v     <= 1'b0;
      p_first <= 1'b0;
      p_last  <= 1'b0;
      acc     <= '0;
      a_last  <= 1'b0;
      res     <= '0;
      res_vld <= 1'b0;
    end else begin
      p_v     <= en && in_v;
      p_first <= in_first;
      p_last  <= in_last;
      if (en && p_v) acc <= p_first ? sum : acc + sum;
      a_last  <= en && p_v && p_last;
      res_vld <= en && a_last;
      if (en && a_last) res <= acc[OW-1:0];
    end
  end

  // R9: a result is only ever issued at an edge where the filter ran
  p_vld_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> $past(en));

endmodule

// File: rtl/rate_fold_fir.sv
module rate_fold_fir
  import fir_fold_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int OW    = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic [1:0]                  speed,
  input  logic                        decim,
  input  logic [DW-1:0]               din,
  input  logic                        cw_we,
  input  logic [$clog2(SLOTS*8)-1:0]  cw_addr,
  input  logic [CW-1:0]               cw_data,
  output logic [OW-1:0]               res,
  output logic                        res_vld,
  output logic                        rate_clk
);

  localparam int PHW  = 3;
  localparam int TAPS = SLOTS << PHW;
  localparam int AW   = DW + CW + $clog2(TAPS);

  logic [PHW-1:0]           ph;
  logic                     ph_first, ph_last;
  logic                     shift_one, shift_two, pend_ld, run;
  logic [SLOTS-1:0][CW-1:0] coef_q;
  logic [SLOTS-1:0][DW-1:0] slice_q;
  logic [DW-1:0]            line_newest;
  logic                     s0_v, s0_first, s0_last;

  fir_fold_ctrl #(.PHW(PHW)) u_ctrl (
    .clk(clk), .rst(rst), .en(en), .speed(speed), .decim(decim),
    .ph(ph), .ph_first(ph_first), .ph_last(ph_last),
    .shift_one(shift_one), .shift_two(shift_two), .pend_ld(pend_ld),
    .run(run), .rate_clk(rate_clk)
  );

  fir_fold_coef #(.CW(CW), .SLOTS(SLOTS), .PHW(PHW)) u_coef (
    .clk(clk), .wr_en(cw_we), .wr_addr(cw_addr), .wr_data(cw_data),
    .rd_ph(ph), .coef_q(coef_q)
  );

  fir_fold_line #(.DW(DW), .SLOTS(SLOTS), .PHW(PHW)) u_line (
    .clk(clk), .rst(rst), .shift_one(shift_one), .shift_two(shift_two),
    .pend_ld(pend_ld), .din(din), .rd_ph(ph), .slice_q(slice_q),
    .newest(line_newest)
  );

  // phase tags travel alongside the registered coefficient and data reads
  always_ff @(posedge clk) begin
    if (rst) begin
      s0_v     <= 1'b0;
      s0_first <= 1'b0;
      s0_last  <= 1'b0;
    end else begin
      s0_v     <= en && run;
      s0_first <= ph_first;
      s0_last  <= ph_last;
    end
  end

  fir_fold_mac #(.DW(DW), .CW(CW), .SLOTS(SLOTS), .OW(OW), .AW(AW)) u_mac (
    .clk(clk), .rst(rst), .en(en), .in_v(s0_v), .in_first(s0_first),
    .in_last(s0_last), .coef(coef_q), .data(slice_q),
    .res(res), .res_vld(res_vld)
  );

  // R9: the newest stored sample does not move while disabled
  p_line_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(line_newest));

  // R2: folded settings never issue back-to-back results
  p_out_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (res_vld && speed != 2'd0) |=> !res_vld);

  // R7: decimating setting never issues back-to-back results either
  p_dec_gap_r7: assert property (@(posedge clk) disable iff (rst)
    (res_vld && decim && speed == 2'd1) |=> !res_vld);

endmodule

// File: tb/rate_fold_fir_tb.sv
module rate_fold_fir_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [1:0]  speed = 2'd0;
  logic        decim = 1'b0;
  logic [15:0] din = '0;
  logic        cw_we = 1'b0;
  logic [6:0]  cw_addr = '0;
  logic [15:0] cw_data = '0;
  logic [31:0] res;
  logic        res_vld;
  logic        rate_clk;

  always #4 clk = ~clk;

  rate_fold_fir u_dut (
    .clk(clk), .rst(rst), .en(en), .speed(speed), .decim(decim), .din(din),
    .cw_we(cw_we), .cw_addr(cw_addr), .cw_data(cw_data),
    .res(res), .res_vld(res_vld), .rate_clk(rate_clk)
  );

  int    total = 0;
  int    bad = 0;
  int    ec = 0;
  int    cyc = 0;
  bit    live = 0;
  bit    done = 0;
  string tag = "R2";

  int    mc [128];
  int    hist [$];
  int    due_q [$];
  int    val_q [$];
  int    cnt = 0;
  bit    pair = 0;
  bit    exp_rate = 1;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, ec);
    end
  endtask

  function automatic int conv(int taps);
    longint y = 0;
    for (int t = 0; t < taps; t++) y += longint'(mc[t]) * longint'(hist[t]);
    return int'(y[31:0]);
  endfunction

  // behavioural reference: sample timing, window and due edge
  always @(posedge clk) begin
    if (rst) begin
      ec = 0; cnt = 0; pair = 0; exp_rate = 1;
      due_q.delete(); val_q.delete(); hist.delete();
      for (int i = 0; i < 128; i++) hist.push_front(0);
    end else begin
      bit dec_on;
      int per, taps, lat;
      ec++;
      dec_on = decim && (speed == 2'd1);
      per    = dec_on ? 2 : (1 << speed);
      taps   = dec_on ? 64 : (16 << speed);
      lat    = dec_on ? 7 : per + 3;
      if (!en) begin
        cnt = 0; pair = 0;
        due_q.delete(); val_q.delete();
        exp_rate = 1;
      end else begin
        if (cnt == 0) begin
          hist.push_front(int'($signed(din)));
          if (hist.size() > 200) void'(hist.pop_back());
          if (!dec_on || pair) begin
            due_q.push_back(ec + lat);
            val_q.push_back(conv(taps));
          end
          if (dec_on) pair = !pair;
        end
        cnt = (cnt + 1) % per;
        exp_rate = (speed == 2'd0) ? 1'b1 : (((per - cnt) % per) < per / 2);
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (live && !rst) begin
      bit ev;
      ev = (due_q.size() > 0) && (due_q[0] == ec);
      chk(res_vld == ev, "R5", "res_vld timing", res_vld, ev);
      if (ev) begin
        chk(res == val_q[0], tag, "result value", $signed(res), val_q[0]);
        void'(due_q.pop_front());
        void'(val_q.pop_front());
      end
      chk(rate_clk == exp_rate, "R6", "rate_clk", rate_clk, exp_rate);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int pat(int p, int k);
    case (p)
      0: return (k * 37) % 200 - 100;
      1: return ((k % 2) != 0 ? 500 : -500) + k;
      2: return (k * 7919 + 13) % 4001 - 2000;
      3: return (k == 0) ? 3000 : ((k % 17 == 0) ? -700 : 5);
      default: return (k % 3 == 0) ? -32768 : 32767;
    endcase
  endfunction

  // R10: coefficients go to tap address t
  task automatic load_coefs(int set);
    for (int t = 0; t < 128; t++) begin
      int c;
      c = (set == 0) ? ((t * 29 + 7) % 41) - 20 : ((t % 2) != 0 ? 32767 : -32768);
      @(negedge clk);
      cw_we = 1; cw_addr = 7'(t); cw_data = 16'(c);
      mc[t] = c;
    end
    @(negedge clk);
    cw_we = 0;
  endtask

  task automatic run(int spd, bit dc, int n, int p, string t, int gap);
    @(negedge clk);
    speed = 2'(spd); decim = dc; tag = t;
    repeat (3) @(negedge clk);
    en = 1;
    for (int k = 0; k < n; k++) begin
      din = 16'(pat(p, k));
      if (gap > 0 && k == n / 2) begin
        en = 0;   // R9: samples offered while disabled must be ignored
        for (int g = 0; g < gap; g++) begin
          din = 16'(12345 + g);
          @(negedge clk);
        end
        en = 1;
      end
      @(negedge clk);
    end
    en = 0;
    repeat (14) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk(res_vld == 0, "R1", "res_vld after reset", res_vld, 0);
    chk(res == 0, "R1", "res after reset", res, 0);
    chk(rate_clk == 1, "R1", "rate_clk after reset", rate_clk, 1);
    live = 1;
    load_coefs(0);
    run(0, 0, 60, 3, "R4", 0);       // impulse first: first sample lands in tap 0
    run(0, 0, 60, 0, "R2", 0);
    run(1, 0, 90, 1, "R2", 0);
    run(2, 0, 330, 2, "R2", 0);
    run(3, 0, 1150, 0, "R2", 0);
    run(1, 1, 200, 2, "R7", 0);
    run(3, 1, 300, 1, "R8", 0);
    run(0, 1, 50, 2, "R8", 0);
    run(1, 0, 120, 0, "R9", 7);
    run(1, 1, 160, 1, "R9", 5);
    load_coefs(1);
    run(2, 0, 200, 3, "R10", 0);
    run(3, 0, 1100, 4, "R3", 0);     // full-scale: forces 32-bit truncation
    live = 0;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule